// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches a bank of asynchronous external lines and turns selected transitions on them into interrupt requests and event pulses. Software enables rising-edge detection, falling-edge detection, or both, per line. A detected edge latches a per-line pending flag. The single interrupt output is raised while any pending flag is unmasked. A one-cycle event pulse is raised on the line's event output when that line's event mask bit is set. Software can also raise a line by hand through a software-trigger register, and it clears pending flags by writing ones to them.

Each external input first passes through a two-flop synchronizer. An edge is found by comparing the synchronized value with its value one cycle earlier, so steady levels never trigger. A change that is driven before clock edge k sets the pending flag and the event pulse at edge k+2. A write to a trigger-select register in the cycle where an edge would be accepted suppresses the edges that register governs. Line 18 and every position from 23 upward are hard-wired reserved.

Register offsets (byte addresses) are: interrupt mask 0x00, event mask 0x04, rising select 0x08, falling select 0x0C, software trigger 0x10, pending 0x14. Reads are combinational. Writes take effect at the clock edge where the write strobe is high.

Top module: `eic_ctrl`

## Requirements
- R1: After reset, all six registers read zero, `irq_o` is 0 and `evt_o` is all zeros.
- R2: On a line whose rising-select bit (0x08) is 1, a 0→1 input change driven before clock edge k sets that line's pending bit (0x14) at edge k+2.
- R3: On a line whose falling-select bit (0x0C) is 1, a 1→0 change sets the pending bit with the same timing as R2. With both select bits set, either direction triggers.
- R4: An edge whose select bit is 0 does not set the pending bit, and a level held steady for many cycles never sets it.
- R5: A write to 0x08 in the cycle a rising edge would be accepted (edge k+2) suppresses that rising trigger. A write to 0x0C suppresses a falling trigger in the same way. A write to one of these registers does not block the other edge direction.
- R6: Bit 18 and bits 31:23 of every register read zero and ignore writes. Those lines never become pending.
- R7: Writing 1 to a bit of 0x10 whose current value is 0 sets that software bit and the line's pending bit at the same edge. The software bit clears when the pending bit is cleared.
- R8: Writing 1 to a bit of 0x14 clears it, and writing 0 leaves it unchanged. If a clear and a new trigger coincide on one line, the bit stays set.
- R9: `irq_o` is 1 exactly when some pending bit has its interrupt-mask bit (0x00) set, and it follows the registers with no delay.
- R10: `evt_o[i]` is high for exactly the one cycle after the edge that accepts a trigger on line i, and only if event-mask bit i (0x04) is 1. Pending is set regardless of the event mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_line_i | input | NUM_LINES | Asynchronous external lines |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 5 | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| irq_o | output | 1 | OR of unmasked pending flags |
| evt_o | output | NUM_LINES | Per-line one-cycle event pulses |

## Verification
The hardest situations to reach are the collisions: a register write that lands on the exact clock edge where a synchronized edge is accepted. The bench drives the line on a falling clock edge and counts two more falling edges. It then holds a write to a select register, or a clear of the pending register, across the next rising edge. This places the collision on the accepting edge and nowhere else. A sweep over every line and all four select combinations, in both edge directions, then covers the reserved position and the ordinary lines alike.

// File: rtl/eic_pkg.sv
package eic_pkg;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 5;

    typedef enum logic [ADDR_W-1:0] {
        OFS_IMASK  = 5'h00,
        OFS_EMASK  = 5'h04,
        OFS_RSEL   = 5'h08,
        OFS_FSEL   = 5'h0C,
        OFS_SWTRIG = 5'h10,
        OFS_PEND   = 5'h14
    } reg_ofs_e;
endpackage

// File: rtl/eic_sync_edge.sv
module eic_sync_edge #(
    parameter int NUM_LINES = 23
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] async_in,
    output logic [NUM_LINES-1:0] rise,
    output logic [NUM_LINES-1:0] fall
);
    // per line: [0] first sync stage, [1] synchronized, [2] previous value
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic [2:0] pipe_q;
        always_ff @(posedge clk) begin
            if (!rst_n) pipe_q <= '0;
            else        pipe_q <= {pipe_q[1:0], async_in[g]};
        end
        assign rise[g] =  pipe_q[1] & ~pipe_q[2];
        assign fall[g] = ~pipe_q[1] &  pipe_q[2];
    end
endmodule

// File: rtl/eic_trig_gate.sv
module eic_trig_gate #(
    parameter int NUM_LINES = 23
) (
    input  logic [NUM_LINES-1:0] rise,
    input  logic [NUM_LINES-1:0] fall,
    input  logic [NUM_LINES-1:0] rsel,
    input  logic [NUM_LINES-1:0] fsel,
    input  logic                 rsel_busy,
    input  logic                 fsel_busy,
    output logic [NUM_LINES-1:0] hw_trig
);
    logic [NUM_LINES-1:0] r_ok, f_ok;
    always_comb begin
        r_ok    = rsel_busy ? '0 : (rise & rsel);
        f_ok    = fsel_busy ? '0 : (fall & fsel);
        hw_trig = r_ok | f_ok;
    end
endmodule

// File: rtl/eic_regs.sv
module eic_regs
    import eic_pkg::*;
#(
    parameter int                   NUM_LINES = 23,
    parameter logic [NUM_LINES-1:0] LINE_MASK = '1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [REG_W-1:0]     bus_wdata,
    output logic [REG_W-1:0]     bus_rdata,
    input  logic [NUM_LINES-1:0] hw_trig,
    output logic [NUM_LINES-1:0] imask,
    output logic [NUM_LINES-1:0] rsel,
    output logic [NUM_LINES-1:0] fsel,
    output logic [NUM_LINES-1:0] pend,
    output logic [NUM_LINES-1:0] evt
);
    logic [NUM_LINES-1:0] imask_q, emask_q, rsel_q, fsel_q, swi_q, pend_q, evt_q;
    logic [NUM_LINES-1:0] wd, sw_set, trig_all, clr, pend_d, swi_d;
    logic                 wr_pend, wr_swi;
    logic                 unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[REG_W-1:NUM_LINES];

    always_comb begin
        wd       = bus_wdata[NUM_LINES-1:0] & LINE_MASK;
        wr_pend  = bus_wr && (bus_addr == OFS_PEND);
        wr_swi   = bus_wr && (bus_addr == OFS_SWTRIG);
        sw_set   = wr_swi ? (wd & ~swi_q) : '0;
        trig_all = (hw_trig & LINE_MASK) | sw_set;
        clr      = wr_pend ? wd : '0;
        pend_d   = (pend_q & ~clr) | trig_all;
        swi_d    = (swi_q | sw_set) & pend_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imask_q <= '0;
            emask_q <= '0;
            rsel_q  <= '0;
            fsel_q  <= '0;
            swi_q   <= '0;
            pend_q  <= '0;
            evt_q   <= '0;
        end else begin
            if (bus_wr && bus_addr == OFS_IMASK) imask_q <= wd;
            if (bus_wr && bus_addr == OFS_EMASK) emask_q <= wd;
            if (bus_wr && bus_addr == OFS_RSEL)  rsel_q  <= wd;
            if (bus_wr && bus_addr == OFS_FSEL)  fsel_q  <= wd;
            swi_q  <= swi_d;
            pend_q <= pend_d;
            evt_q  <= trig_all & emask_q;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_IMASK:  bus_rdata[NUM_LINES-1:0] = imask_q;
            OFS_EMASK:  bus_rdata[NUM_LINES-1:0] = emask_q;
            OFS_RSEL:   bus_rdata[NUM_LINES-1:0] = rsel_q;
            OFS_FSEL:   bus_rdata[NUM_LINES-1:0] = fsel_q;
            OFS_SWTRIG: bus_rdata[NUM_LINES-1:0] = swi_q;
            OFS_PEND:   bus_rdata[NUM_LINES-1:0] = pend_q;
            default:    bus_rdata = '0;
        endcase
    end

    assign imask = imask_q;
    assign rsel  = rsel_q;
    assign fsel  = fsel_q;
    assign pend  = pend_q;
    assign evt   = evt_q;

    AST_TRIG_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (|trig_all) |=> ((pend_q & $past(trig_all)) == $past(trig_all))); // R2
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pend |=> ((pend_q & $past(clr & ~trig_all)) == '0)); // R8
    AST_SWI_TRACKS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        ((swi_q & ~pend_q) == '0)); // R7
    AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (((pend_q | imask_q | emask_q | rsel_q | fsel_q | swi_q) & ~LINE_MASK) == '0)); // R6
    AST_EVT_WITH_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_q & ~pend_q) == '0)); // R10
endmodule

// File: rtl/eic_ctrl.sv
module eic_ctrl
    import eic_pkg::*;
#(
    parameter int          NUM_LINES  = 23,
    parameter logic [31:0] VALID_MASK = 32'h007B_FFFF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] ext_line_i,
    input  logic                 bus_wr_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [REG_W-1:0]     bus_wdata_i,
    output logic [REG_W-1:0]     bus_rdata_o,
    output logic                 irq_o,
    output logic [NUM_LINES-1:0] evt_o
);
    localparam logic [NUM_LINES-1:0] LMASK = VALID_MASK[NUM_LINES-1:0];

    logic [NUM_LINES-1:0] rise, fall, hw_trig, imask, rsel, fsel, pend;
    logic                 rsel_busy, fsel_busy;

    assign rsel_busy = bus_wr_i && (bus_addr_i == OFS_RSEL);
    assign fsel_busy = bus_wr_i && (bus_addr_i == OFS_FSEL);

    eic_sync_edge #(.NUM_LINES(NUM_LINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ext_line_i), .rise(rise), .fall(fall)
    );

    eic_trig_gate #(.NUM_LINES(NUM_LINES)) u_gate (
        .rise(rise), .fall(fall), .rsel(rsel), .fsel(fsel),
        .rsel_busy(rsel_busy), .fsel_busy(fsel_busy), .hw_trig(hw_trig)
    );

    eic_regs #(.NUM_LINES(NUM_LINES), .LINE_MASK(LMASK)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr_i), .bus_addr(bus_addr_i),
        .bus_wdata(bus_wdata_i), .bus_rdata(bus_rdata_o), .hw_trig(hw_trig),
        .imask(imask), .rsel(rsel), .fsel(fsel), .pend(pend), .evt(evt_o)
    );

    assign irq_o = |(pend & imask);

    AST_RSEL_WR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        rsel_busy |-> ((hw_trig & rise) == '0)); // R5
    AST_FSEL_WR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        fsel_busy |-> ((hw_trig & fall) == '0)); // R5
    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend != '0)); // R9
endmodule

// File: tb/eic_ctrl_tb.sv
module eic_ctrl_tb_top;
    import eic_pkg::*;
    localparam int          N     = 23;
    localparam logic [31:0] VALID = 32'h007B_FFFF;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [N-1:0]         ext = '0;
    logic                 wr = 1'b0;
    logic [ADDR_W-1:0]    addr = '0;
    logic [REG_W-1:0]     wdata = '0;
    logic [REG_W-1:0]     rdata;
    logic                 irq;
    logic [N-1:0]         evt;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    eic_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ext_line_i(ext), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_o(irq), .evt_o(evt)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    // drive a line, then stop at the falling clock edge where pending first shows
    task automatic drive_and_wait(input int i, input bit v);
        @(negedge clk);
        ext[i] = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            bus_read(ADDR_W'(a * 4), rd);
            check("R1 reg reset", rd, 32'h0);
        end
        check("R1 irq reset", {31'h0, irq}, 32'h0);
        check("R1 evt reset", {9'h0, evt}, 32'h0);

        // R6 reserved positions ignore writes
        for (int a = 0; a < 4; a++) begin
            bus_write(ADDR_W'(a * 4), 32'hFFFF_FFFF);
            bus_read(ADDR_W'(a * 4), rd);
            check("R6 reserved read zero", rd, VALID);
            bus_write(ADDR_W'(a * 4), 32'h0);
        end

        // R2 R3 R4 R9 R10 sweep: every line, every select combination, both directions
        for (int i = 0; i < N; i++) begin
            for (int cfg = 0; cfg < 4; cfg++) begin
                logic [31:0] bitv, er, ef;
                bitv = 32'h1 << i;
                er = cfg[0] ? (bitv & VALID) : 32'h0;
                ef = cfg[1] ? (bitv & VALID) : 32'h0;
                bus_write(OFS_RSEL, cfg[0] ? bitv : 32'h0);
                bus_write(OFS_FSEL, cfg[1] ? bitv : 32'h0);
                bus_write(OFS_EMASK, 32'hFFFF_FFFF);
                bus_write(OFS_IMASK, bitv);
                drive_and_wait(i, 1'b1);
                bus_read(OFS_PEND, rd);
                check("R2 rising pend", rd, er);
                check("R10 rising evt", {9'h0, evt}, er);
                check("R9 rising irq", {31'h0, irq}, {31'h0, |er});
                @(negedge clk);
                check("R10 evt one cycle", {9'h0, evt}, 32'h0);
                bus_write(OFS_PEND, 32'hFFFF_FFFF);
                repeat (6) @(negedge clk);
                bus_read(OFS_PEND, rd);
                check("R4 steady high", rd, 32'h0);
                drive_and_wait(i, 1'b0);
                bus_read(OFS_PEND, rd);
                check("R3 falling pend", rd, ef);
                check("R10 falling evt", {9'h0, evt}, ef);
                bus_write(OFS_PEND, 32'hFFFF_FFFF);
                check("R8 cleared irq", {31'h0, irq}, 32'h0);
                repeat (6) @(negedge clk);
                bus_read(OFS_PEND, rd);
                check("R4 steady low", rd, 32'h0);
            end
        end

        // R5: select write collides with the accepting edge
        bus_write(OFS_RSEL, 32'h8);
        bus_write(OFS_FSEL, 32'h8);
        @(negedge clk); ext[3] = 1'b1;
        @(negedge clk); @(negedge clk);
        wr = 1'b1; addr = OFS_RSEL; wdata = 32'h8;
        @(negedge clk); wr = 1'b0;
        bus_read(OFS_PEND, rd);
        check("R5 rising blocked by rsel write", rd, 32'h0);
        @(negedge clk); ext[3] = 1'b0;
        @(negedge clk); @(negedge clk);
        wr = 1'b1; addr = OFS_FSEL; wdata = 32'h8;
        @(negedge clk); wr = 1'b0;
        bus_read(OFS_PEND, rd);
        check("R5 falling blocked by fsel write", rd, 32'h0);
        @(negedge clk); ext[3] = 1'b1;
        @(negedge clk); @(negedge clk);
        wr = 1'b1; addr = OFS_FSEL; wdata = 32'h8;
        @(negedge clk); wr = 1'b0;
        bus_read(OFS_PEND, rd);
        check("R5 rising not blocked by fsel write", rd, 32'h8);
        bus_write(OFS_PEND, 32'h8);

        // R8: clear and trigger on the same edge
        @(negedge clk); ext[3] = 1'b0;
        @(negedge clk); @(negedge clk);
        wr = 1'b1; addr = OFS_PEND; wdata = 32'h8;
        @(negedge clk); wr = 1'b0;
        bus_read(OFS_PEND, rd);
        check("R8 trigger wins over clear", rd, 32'h8);
        bus_write(OFS_PEND, 32'h0);
        bus_read(OFS_PEND, rd);
        check("R8 write zero keeps", rd, 32'h8);
        bus_write(OFS_PEND, 32'h8);
        bus_read(OFS_PEND, rd);
        check("R8 write one clears", rd, 32'h0);

        // R7 software trigger, with R10 event and R6 reserved bit
        bus_write(OFS_EMASK, 32'h20);
        bus_write(OFS_IMASK, 32'h0);
        bus_write(OFS_SWTRIG, 32'h0004_0020);
        check("R7 sw event", {9'h0, evt}, 32'h20);
        bus_read(OFS_SWTRIG, rd);
        check("R7 sw bit set", rd, 32'h20);
        bus_read(OFS_PEND, rd);
        check("R7 sw pend", rd, 32'h20);
        check("R9 masked irq", {31'h0, irq}, 32'h0);
        bus_write(OFS_IMASK, 32'h20);
        check("R9 unmasked irq", {31'h0, irq}, 32'h1);
        bus_write(OFS_PEND, 32'h20);
        bus_read(OFS_SWTRIG, rd);
        check("R7 sw bit clears", rd, 32'h0);

        // R10 event mask off: pending still set, no event
        bus_write(OFS_EMASK, 32'h0);
        bus_write(OFS_RSEL, 32'h2);
        drive_and_wait(1, 1'b1);
        check("R10 masked evt", {9'h0, evt}, 32'h0);
        bus_read(OFS_PEND, rd);
        check("R10 pend without evt", rd, 32'h2);

        summary();
    end
endmodule